// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block sits next to an 8-bit microcontroller core and decides, once per instruction boundary, whether an interrupt is to be entered and which one. It looks at a non-maskable edge input, two external level requests gated by a pair of enable bits from the core's RAM/port control register, and a set of on-chip timer and serial flags with their enables. It then picks the single winner of a fixed priority chain. The result is a one-cycle take strobe, the 16-bit vector fetch address and a source code. The core uses these to begin its stacking sequence.

The arbiter also tracks the timing rules of the core. An instruction that clears the mask flag while it was set, or that copies the accumulator into the condition codes, pushes evaluation past one more instruction. An illegal-opcode trap forces its own vector at once. A write to the control register re-runs the arbitration without waiting for a boundary. Any request seen at an evaluation wakes a sleeping core, even when the mask flag keeps the request from being taken. When the core was already waiting with its registers stacked, the arbiter flags that the short entry path applies.

Top module: `irq_vector_arbiter`

## Requirements
- R1: During and right after synchronous reset, `take_o`, `wake_o` and `short_stack_o` are 0, `vector_o` is 0x0000 and `src_o` is 0 (none).
- R2: A rising edge on `nmi_i` sets a pending latch, and that edge also counts in its own cycle. At an evaluation the pending NMI wins over every other source whatever `mask_i` is. It gives vector 0xFFFC and source code 1, and the latch clears only when the NMI is taken.
- R3: The first external request is active when `irq1_i` and `ctl_en_i[0]` are both 1. It outranks all on-chip sources and is taken with vector 0xFFF8 and source code 2 only when `mask_i` is 0. While it is active and masked, no lower source is taken.
- R4: When the first external request is inactive, the secondary sources are checked in this order, with these vectors and source codes: input strobe 0xFFF8/3, input capture 0xFFF6/4, output compare 0xFFF4/5, timer overflow 0xFFF2/6, counter match 0xFFEC/7, second external 0xFFEA/8, serial 0xFFF0/9. Each is taken only when `mask_i` is 0.
- R5: Counter match requests only when both bits of `tmatch_i` are 1 (they mirror bits 7 and 6 of its timer status register).
- R6: The second external source requests only when `irq2_i` and `ctl_en_i[1]` are both 1.
- R7: Output compare requests when any compare flag is set together with its enable. Serial requests when (`rx_en_i` and `rx_full_i`) or (`tx_en_i` and `tx_empty_i`).
- R8: `wake_o` pulses one cycle after any evaluation that finds NMI pending, the first external request active, or any secondary source active, whether or not it is taken.
- R9: `short_stack_o` pulses together with `take_o` when `wait_i` was 1 in the cycle the interrupt was chosen.
- R10: A boundary with `cli_i` set while the mask was 1 in the previous cycle, or with `tap_i` set, is skipped: nothing is taken or woken at it, and the next boundary evaluates normally.
- R11: `trap_i` forces a take with vector 0xFFEE and source code 10 in the next cycle, whatever the mask, boundary or pending requests. A pending NMI stays latched.
- R12: `ctl_wr_i` starts an evaluation in a cycle without a boundary, and the deferral of R10 does not apply to it.
- R13: Outputs are registered: `take_o` is high for one cycle, one clock after the cycle of the decision, and `vector_o`/`src_o` keep their last taken values until the next take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Instruction boundary: evaluate pending sources |
| trap_i | input | 1 | Illegal-opcode trap |
| cli_i | input | 1 | Boundary follows a clear-mask instruction |
| tap_i | input | 1 | Boundary follows a transfer to condition codes |
| mask_i | input | 1 | Interrupt mask flag of the core |
| wait_i | input | 1 | Core is in the wait state with registers stacked |
| ctl_en_i | input | 2 | External enables from the control register ([0] first, [1] second) |
| ctl_wr_i | input | 1 | Control register was written |
| nmi_i | input | 1 | Non-maskable request, edge-sensed |
| irq1_i | input | 1 | First external request level |
| irq2_i | input | 1 | Second external request level |
| strb_i | input | 1 | Input strobe flag (variant with strobe) |
| cap_flag_i | input | 1 | Input capture flag |
| cap_en_i | input | 1 | Input capture enable |
| cmp_flag_i | input | NCMP | Output compare flags |
| cmp_en_i | input | NCMP | Output compare enables |
| ovf_flag_i | input | 1 | Timer overflow flag |
| ovf_en_i | input | 1 | Timer overflow enable |
| tmatch_i | input | 2 | Counter match status bits ([1]=bit 7, [0]=bit 6) |
| rx_en_i | input | 1 | Serial receive interrupt enable |
| rx_full_i | input | 1 | Serial receive register full |
| tx_en_i | input | 1 | Serial transmit interrupt enable |
| tx_empty_i | input | 1 | Serial transmit register empty |
| take_o | output | 1 | Take-interrupt strobe |
| vector_o | output | 16 | Vector fetch address |
| src_o | output | 4 | Source code of the taken interrupt |
| wake_o | output | 1 | Clear the sleep state |
| short_stack_o | output | 1 | Entry from wait: short cycle accounting |

## Verification
The bench aims at the places where the chain is easy to get wrong. A masked first external request must block the secondary sources and still wake the core. A design that fell through the chain would take a timer vector there. Counter match with only one status bit set, and the second external line with its enable clear, must stay silent, or the bench sees a stray 0xFFEC or 0xFFEA. Deferral after a mask clear must skip exactly one boundary and must not hold off a control-register write. An NMI edge that lands outside a boundary must stay pending until the next evaluation, and a trap must leave it pending. Random traffic with mixed masks, enables and deferrals then compares every cycle against a priority model in the bench.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  typedef enum logic [3:0] {
    SRC_NONE = 4'd0, SRC_NMI  = 4'd1, SRC_IRQ1 = 4'd2, SRC_STRB = 4'd3,
    SRC_ICAP = 4'd4, SRC_OCMP = 4'd5, SRC_TOVF = 4'd6, SRC_CMAT = 4'd7,
    SRC_IRQ2 = 4'd8, SRC_SER  = 4'd9, SRC_TRAP = 4'd10
  } src_e;

  localparam int NSEC = 7;
  localparam logic [15:0] VEC_NMI  = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ1 = 16'hFFF8;
  localparam logic [15:0] VEC_TRAP = 16'hFFEE;

  // secondary chain, index 0 has the highest priority
  function automatic logic [15:0] sec_vector(input int idx);
    case (idx)
      0: sec_vector = 16'hFFF8;
      1: sec_vector = 16'hFFF6;
      2: sec_vector = 16'hFFF4;
      3: sec_vector = 16'hFFF2;
      4: sec_vector = 16'hFFEC;
      5: sec_vector = 16'hFFEA;
      default: sec_vector = 16'hFFF0;
    endcase
  endfunction

  function automatic src_e sec_code(input int idx);
    case (idx)
      0: sec_code = SRC_STRB;
      1: sec_code = SRC_ICAP;
      2: sec_code = SRC_OCMP;
      3: sec_code = SRC_TOVF;
      4: sec_code = SRC_CMAT;
      5: sec_code = SRC_IRQ2;
      default: sec_code = SRC_SER;
    endcase
  endfunction
endpackage

// File: rtl/irqarb_nmi_latch.sv
module irqarb_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q;
  logic edge_w;

  assign edge_w = nmi_i & ~prev_q;
  assign pend_o = pend_q | edge_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_i;
      pend_q <= pend_o & ~clr_i;
    end
  end

  // a latched NMI is only dropped by taking it
  assert_nmi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    pend_q && !clr_i |=> pend_q);
endmodule

// File: rtl/irqarb_src_req.sv
module irqarb_src_req #(
  parameter int NCMP       = 3,
  parameter bit HAS_STROBE = 1'b1,
  parameter int NSRC       = irqarb_pkg::NSEC
) (
  input  logic            strb_i,
  input  logic            cap_flag_i,
  input  logic            cap_en_i,
  input  logic [NCMP-1:0] cmp_flag_i,
  input  logic [NCMP-1:0] cmp_en_i,
  input  logic            ovf_flag_i,
  input  logic            ovf_en_i,
  input  logic [1:0]      tmatch_i,
  input  logic            irq2_i,
  input  logic            irq2_en_i,
  input  logic            rx_en_i,
  input  logic            rx_full_i,
  input  logic            tx_en_i,
  input  logic            tx_empty_i,
  output logic [NSRC-1:0] req_o
);
  logic [NCMP-1:0] cmp_hit;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign cmp_hit[g] = cmp_flag_i[g] & cmp_en_i[g];
  end

  if (HAS_STROBE) begin : g_strb
    assign req_o[0] = strb_i;
  end else begin : g_nostrb
    assign req_o[0] = 1'b0;
  end

  assign req_o[1] = cap_flag_i & cap_en_i;
  assign req_o[2] = |cmp_hit;                      // R7
  assign req_o[3] = ovf_flag_i & ovf_en_i;
  assign req_o[4] = &tmatch_i;                     // R5
  assign req_o[5] = irq2_i & irq2_en_i;            // R6
  assign req_o[6] = (rx_en_i & rx_full_i) | (tx_en_i & tx_empty_i);
endmodule

// File: rtl/irqarb_pick.sv
module irqarb_pick #(
  parameter int N  = irqarb_pkg::NSEC,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  // R4: the winner must itself be requesting and nothing ahead of it
  always_comb begin
    if (found_o) begin
      assert_pick_valid_R4: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irqarb_pkg::*;
#(
  parameter int NCMP       = 3,
  parameter bit HAS_STROBE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            eval_i,
  input  logic            trap_i,
  input  logic            cli_i,
  input  logic            tap_i,
  input  logic            mask_i,
  input  logic            wait_i,
  input  logic [1:0]      ctl_en_i,
  input  logic            ctl_wr_i,
  input  logic            nmi_i,
  input  logic            irq1_i,
  input  logic            irq2_i,
  input  logic            strb_i,
  input  logic            cap_flag_i,
  input  logic            cap_en_i,
  input  logic [NCMP-1:0] cmp_flag_i,
  input  logic [NCMP-1:0] cmp_en_i,
  input  logic            ovf_flag_i,
  input  logic            ovf_en_i,
  input  logic [1:0]      tmatch_i,
  input  logic            rx_en_i,
  input  logic            rx_full_i,
  input  logic            tx_en_i,
  input  logic            tx_empty_i,
  output logic            take_o,
  output logic [15:0]     vector_o,
  output logic [3:0]      src_o,
  output logic            wake_o,
  output logic            short_stack_o
);
  localparam int IW = $clog2(NSEC);

  logic [NSEC-1:0] sec_req;
  logic            sec_found;
  logic [IW-1:0]   sec_idx;
  logic            nmi_pend, nmi_clr;
  logic            mask_q;
  logic            defer, go, irq1_req;
  logic            take_d, wake_d;
  logic [15:0]     vec_d;
  src_e            src_d;

  irqarb_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .nmi_i(nmi_i), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  irqarb_src_req #(.NCMP(NCMP), .HAS_STROBE(HAS_STROBE), .NSRC(NSEC)) u_req (
    .strb_i(strb_i), .cap_flag_i(cap_flag_i), .cap_en_i(cap_en_i),
    .cmp_flag_i(cmp_flag_i), .cmp_en_i(cmp_en_i),
    .ovf_flag_i(ovf_flag_i), .ovf_en_i(ovf_en_i), .tmatch_i(tmatch_i),
    .irq2_i(irq2_i), .irq2_en_i(ctl_en_i[1]),
    .rx_en_i(rx_en_i), .rx_full_i(rx_full_i),
    .tx_en_i(tx_en_i), .tx_empty_i(tx_empty_i), .req_o(sec_req)
  );

  irqarb_pick #(.N(NSEC), .IW(IW)) u_pick (
    .req_i(sec_req), .found_o(sec_found), .idx_o(sec_idx)
  );

  // one-instruction hold-off after mask clear (from set) or condition-code load
  assign defer    = (cli_i & mask_q) | tap_i;
  assign go       = (eval_i & ~defer) | ctl_wr_i;
  assign irq1_req = irq1_i & ctl_en_i[0];

  always_comb begin
    take_d = 1'b0;
    wake_d = 1'b0;
    vec_d  = vector_o;
    src_d  = SRC_NONE;
    if (trap_i) begin
      take_d = 1'b1;
      vec_d  = VEC_TRAP;
      src_d  = SRC_TRAP;
    end else if (go) begin
      if (nmi_pend) begin
        take_d = 1'b1;
        wake_d = 1'b1;
        vec_d  = VEC_NMI;
        src_d  = SRC_NMI;
      end else if (irq1_req) begin
        wake_d = 1'b1;
        take_d = ~mask_i;
        vec_d  = VEC_IRQ1;
        src_d  = SRC_IRQ1;
      end else if (sec_found) begin
        wake_d = 1'b1;
        take_d = ~mask_i;
        vec_d  = sec_vector(int'(sec_idx));
        src_d  = sec_code(int'(sec_idx));
      end
    end
  end

  assign nmi_clr = take_d & (src_d == SRC_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q        <= 1'b1;
      take_o        <= 1'b0;
      vector_o      <= '0;
      src_o         <= SRC_NONE;
      wake_o        <= 1'b0;
      short_stack_o <= 1'b0;
    end else begin
      mask_q        <= mask_i;
      take_o        <= take_d;
      wake_o        <= wake_d;
      short_stack_o <= take_d & wait_i;
      if (take_d) begin
        vector_o <= vec_d;
        src_o    <= src_d;
      end
    end
  end

  assert_irq1_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
    take_o && src_o == SRC_IRQ1 |-> !$past(mask_i));
  assert_irq2_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    take_o && src_o == SRC_IRQ2 |-> $past(irq2_i && ctl_en_i[1]));
  assert_defer_skips_R10: assert property (@(posedge clk) disable iff (rst)
    eval_i && defer && !ctl_wr_i && !trap_i |=> !take_o && !wake_o);
  assert_short_with_take_R9: assert property (@(posedge clk) disable iff (rst)
    short_stack_o |-> take_o);
  assert_nmi_vector_R2: assert property (@(posedge clk) disable iff (rst)
    take_o && src_o == SRC_NMI |-> vector_o == VEC_NMI);
  assert_vector_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> $stable(vector_o) && $stable(src_o));
endmodule

// File: tb/irq_vector_arbiter_test.sv
module irq_vector_arbiter_test;
  localparam int NCMP = 3;

  logic clk = 1'b0;
  logic rst;
  logic eval_i, trap_i, cli_i, tap_i, mask_i, wait_i, ctl_wr_i;
  logic [1:0] ctl_en_i, tmatch_i;
  logic nmi_i, irq1_i, irq2_i, strb_i, cap_flag_i, cap_en_i;
  logic [NCMP-1:0] cmp_flag_i, cmp_en_i;
  logic ovf_flag_i, ovf_en_i, rx_en_i, rx_full_i, tx_en_i, tx_empty_i;
  logic take_o, wake_o, short_stack_o;
  logic [15:0] vector_o;
  logic [3:0] src_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  bit m_pend, m_nprev, m_maskq;
  bit e_take, e_wake, e_short;
  logic [15:0] e_vec;
  logic [3:0] e_src;

  always #4 clk = ~clk;

  irq_vector_arbiter #(.NCMP(NCMP), .HAS_STROBE(1'b1)) uut (
    .clk(clk), .rst(rst), .eval_i(eval_i), .trap_i(trap_i), .cli_i(cli_i),
    .tap_i(tap_i), .mask_i(mask_i), .wait_i(wait_i), .ctl_en_i(ctl_en_i),
    .ctl_wr_i(ctl_wr_i), .nmi_i(nmi_i), .irq1_i(irq1_i), .irq2_i(irq2_i),
    .strb_i(strb_i), .cap_flag_i(cap_flag_i), .cap_en_i(cap_en_i),
    .cmp_flag_i(cmp_flag_i), .cmp_en_i(cmp_en_i), .ovf_flag_i(ovf_flag_i),
    .ovf_en_i(ovf_en_i), .tmatch_i(tmatch_i), .rx_en_i(rx_en_i),
    .rx_full_i(rx_full_i), .tx_en_i(tx_en_i), .tx_empty_i(tx_empty_i),
    .take_o(take_o), .vector_o(vector_o), .src_o(src_o), .wake_o(wake_o),
    .short_stack_o(short_stack_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'd1: tag_of = "R2";
      4'd2: tag_of = "R3";
      4'd5, 4'd9: tag_of = "R7";
      4'd7: tag_of = "R5";
      4'd8: tag_of = "R6";
      4'd10: tag_of = "R11";
      default: tag_of = "R4";
    endcase
  endfunction

  function automatic logic [15:0] vec_of(input int i);
    logic [15:0] t [7] = '{16'hFFF8, 16'hFFF6, 16'hFFF4, 16'hFFF2, 16'hFFEC, 16'hFFEA, 16'hFFF0};
    return t[i];
  endfunction

  task automatic clear_in();
    eval_i = 0; trap_i = 0; cli_i = 0; tap_i = 0; mask_i = 0; wait_i = 0;
    ctl_wr_i = 0; ctl_en_i = 2'b11; tmatch_i = 0; nmi_i = 0; irq1_i = 0;
    irq2_i = 0; strb_i = 0; cap_flag_i = 0; cap_en_i = 0; cmp_flag_i = 0;
    cmp_en_i = 0; ovf_flag_i = 0; ovf_en_i = 0; rx_en_i = 0; rx_full_i = 0;
    tx_en_i = 0; tx_empty_i = 0;
  endtask

  // compute expectation for the inputs now driven, clock once, compare
  task automatic step();
    bit edge_n, p, defer, go, r1, nt, nw;
    bit [6:0] sr;
    logic [15:0] nv;
    logic [3:0] ns;
    edge_n = nmi_i && !m_nprev;
    p = m_pend || edge_n;
    defer = (cli_i && m_maskq) || tap_i;
    go = (eval_i && !defer) || ctl_wr_i;
    r1 = irq1_i && ctl_en_i[0];
    sr[0] = strb_i;
    sr[1] = cap_flag_i && cap_en_i;
    sr[2] = |(cmp_flag_i & cmp_en_i);
    sr[3] = ovf_flag_i && ovf_en_i;
    sr[4] = tmatch_i[1] && tmatch_i[0];
    sr[5] = irq2_i && ctl_en_i[1];
    sr[6] = (rx_en_i && rx_full_i) || (tx_en_i && tx_empty_i);
    nt = 0; nw = 0; nv = 0; ns = 0;
    if (trap_i) begin
      nt = 1; nv = 16'hFFEE; ns = 4'd10;
    end else if (go) begin
      if (p) begin
        nt = 1; nw = 1; nv = 16'hFFFC; ns = 4'd1;
      end else if (r1) begin
        nw = 1; nt = !mask_i; nv = 16'hFFF8; ns = 4'd2;
      end else begin
        for (int i = 6; i >= 0; i--)
          if (sr[i]) begin
            nw = 1; nt = !mask_i; nv = vec_of(i); ns = 4'(i + 3);
          end
      end
    end
    m_pend = p && !(nt && ns == 4'd1);
    m_nprev = nmi_i;
    m_maskq = mask_i;
    e_take = nt;
    e_wake = nw;
    e_short = nt && wait_i;
    if (nt) begin
      e_vec = nv; e_src = ns;
    end
    @(posedge clk);
    @(negedge clk);
    chk(take_o == e_take, e_take ? tag_of(e_src) : "R13 take", 16'(take_o), 16'(e_take));
    chk(wake_o == e_wake, "R8 wake", 16'(wake_o), 16'(e_wake));
    chk(short_stack_o == e_short, "R9 short", 16'(short_stack_o), 16'(e_short));
    chk(vector_o == e_vec, e_take ? tag_of(e_src) : "R13 hold", vector_o, e_vec);
    chk(src_o == e_src, e_take ? tag_of(e_src) : "R13 hold", 16'(src_o), 16'(e_src));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(take_o == 0 && wake_o == 0 && short_stack_o == 0, "R1 strobes", 16'({take_o, wake_o, short_stack_o}), 16'h0);
    chk(vector_o == 0 && src_o == 0, "R1 vector", vector_o, 16'h0);
    rst = 0;
    m_pend = 0; m_nprev = 0; m_maskq = 1;
    e_take = 0; e_wake = 0; e_short = 0; e_vec = 0; e_src = 0;
    step();

    // R3/R8: masked first external blocks capture but still wakes
    clear_in(); mask_i = 1; irq1_i = 1; cap_flag_i = 1; cap_en_i = 1; eval_i = 1; step();
    // R3: enable bit 0 clear lets capture through
    clear_in(); ctl_en_i = 2'b10; irq1_i = 1; cap_flag_i = 1; cap_en_i = 1; eval_i = 1; step();
    // R5: one match bit only, then both
    clear_in(); tmatch_i = 2'b10; eval_i = 1; step();
    clear_in(); tmatch_i = 2'b11; rx_en_i = 1; rx_full_i = 1; eval_i = 1; step();
    // R6: second external disabled, then enabled ahead of serial
    clear_in(); ctl_en_i = 2'b01; irq2_i = 1; eval_i = 1; step();
    clear_in(); irq2_i = 1; tx_en_i = 1; tx_empty_i = 1; eval_i = 1; step();
    // R7: compare lane 2 with its enable
    clear_in(); cmp_flag_i = 3'b110; cmp_en_i = 3'b100; ovf_flag_i = 1; ovf_en_i = 1; eval_i = 1; step();
    // R10: clear mask from set defers one boundary
    clear_in(); mask_i = 1; step();
    clear_in(); cli_i = 1; eval_i = 1; irq1_i = 1; step();
    clear_in(); eval_i = 1; irq1_i = 1; step();
    // R10: condition-code load defers as well
    clear_in(); tap_i = 1; eval_i = 1; strb_i = 1; step();
    // R12: control write evaluates without boundary, even with tap
    clear_in(); ctl_wr_i = 1; tap_i = 1; irq2_i = 1; step();
    // R2: edge outside a boundary stays pending; R11 trap keeps it
    clear_in(); nmi_i = 1; step();
    clear_in(); nmi_i = 1; trap_i = 1; mask_i = 1; eval_i = 1; step();
    clear_in(); nmi_i = 1; mask_i = 1; eval_i = 1; irq1_i = 1; step();
    // R9: entry from wait
    clear_in(); wait_i = 1; eval_i = 1; cap_flag_i = 1; cap_en_i = 1; step();

    // random traffic
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      eval_i = ($urandom % 3) != 0;
      trap_i = ($urandom % 40) == 0;
      cli_i = ($urandom % 6) == 0;
      tap_i = ($urandom % 12) == 0;
      mask_i = ($urandom % 3) == 0;
      wait_i = $urandom % 2;
      ctl_wr_i = ($urandom % 15) == 0;
      ctl_en_i = 2'($urandom);
      nmi_i = ($urandom % 25) == 0 ? !nmi_i : nmi_i;
      irq1_i = ($urandom % 5) == 0;
      irq2_i = ($urandom % 5) == 0;
      strb_i = ($urandom % 8) == 0;
      cap_flag_i = ($urandom % 5) == 0; cap_en_i = $urandom % 2;
      cmp_flag_i = NCMP'($urandom); cmp_en_i = NCMP'($urandom) & NCMP'($urandom);
      ovf_flag_i = ($urandom % 4) == 0; ovf_en_i = $urandom % 2;
      tmatch_i = 2'($urandom);
      rx_en_i = $urandom % 2; rx_full_i = ($urandom % 4) == 0;
      tx_en_i = $urandom % 2; tx_empty_i = ($urandom % 4) == 0;
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule